// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits next to a processor that announces each bus cycle with a 3-bit status code. The code sits at the passive value 111 between cycles. The block watches that code on every rising clock edge. It treats a move away from the passive value as the start of a bus cycle. From the start edge on, it drives the address-latch strobe, the data-transceiver enable and direction, and the active-low command strobes that memory, I/O devices and the interrupt controller respond to.

The kind of cycle is captured once, at the start edge. The cycle runs until the status is seen back at 111. The sequence is: one clock of address latch; then the read, interrupt-acknowledge and advanced-write strobes; then, `WR_LAG` clocks later, the normal write strobes. Halt cycles go through the same phases but drive no command.

Top module: `bus_cmd_decoder`

## Requirements
- R1: After reset all seven command outputs are high (inactive), `addr_latch` and `data_en` are low, and `data_dir` is high.
- R2: A cycle starts on a rising edge that samples a non-111 code while the previous edge sampled 111. `addr_latch` is high for exactly the one clock that follows that edge. A non-111 code held since reset starts nothing until 111 has been sampled.
- R3: Read-type codes drive one command low from the second clock of the cycle (the clock after `addr_latch`): 000 drives `int_ack_n`, 001 drives `io_rd_n`, 100 (fetch) and 101 (memory read) drive `mem_rd_n`.
- R4: Write codes drive the advanced write low from the second clock of the cycle: 010 drives `io_wr_adv_n` and 110 drives `mem_wr_adv_n`.
- R5: The normal write (`io_wr_n` for 010, `mem_wr_n` for 110) goes low `WR_LAG` clocks (default 1) after the advanced write, and both stay low until the cycle ends.
- R6: Code 011 (halt) drives no command and keeps `data_en` low for the whole cycle.
- R7: The edge that samples 111 during a cycle ends it. After that edge all commands are high and `data_en` and `data_dir` return to low and high. If 111 is sampled in the latch clock, no command is ever driven.
- R8: A change between two non-111 codes inside a cycle is ignored. The command set chosen at the start edge is kept.
- R9: `data_dir` is low from the latch clock to the end of the cycle for codes 000, 001, 100 and 101, and high in every other case.
- R10: `data_en` is high exactly in the clocks from the second clock of a non-halt cycle up to its end.
- R11: No more than two command outputs are low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; status is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_status | input | 3 | Cycle status code from the processor, 111 = passive |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| mem_wr_adv_n | output | 1 | Advanced memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| io_wr_adv_n | output | 1 | Advanced I/O write command, active low |
| int_ack_n | output | 1 | Interrupt acknowledge strobe, active low |
| addr_latch | output | 1 | Address latch enable, high for one clock at cycle start |
| data_en | output | 1 | Data transceiver enable, active high |
| data_dir | output | 1 | Transceiver direction, 1 = transmit, 0 = receive |

## Verification
A wrong captured cycle kind shows at the ports in the second clock of the cycle, as the wrong strobe or a wrong `data_dir`. A wrong phase shows up right away, as a stuck or repeated `addr_latch`, or as commands that do not drop on the clock after 111 is sampled. A broken arming flag shows as a cycle launched from a code held through reset. A wrong lag counter moves the normal write edge away from one clock after the advanced write. The directed scenarios sample every clock of each cycle, so each of these faults appears within a few clocks of its cause.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MRD   = 3'b101,
        ST_MWR   = 3'b110,
        ST_IDLE  = 3'b111
    } stat_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // internal command set, active high
    typedef struct packed {
        logic inta;
        logic iord;
        logic iowr;
        logic aiow;
        logic mrd;
        logic mwr;
        logic amw;
    } cmd_t;

    function automatic logic is_receive(stat_e k);
        return (k == ST_INTA) || (k == ST_IORD) || (k == ST_FETCH) || (k == ST_MRD);
    endfunction

    function automatic cmd_t early_cmds(stat_e k);
        cmd_t c;
        c = '0;
        case (k)
            ST_INTA:        c.inta = 1'b1;
            ST_IORD:        c.iord = 1'b1;
            ST_IOWR:        c.aiow = 1'b1;
            ST_FETCH, ST_MRD: c.mrd = 1'b1;
            ST_MWR:         c.amw  = 1'b1;
            default:        c = '0;
        endcase
        return c;
    endfunction

    function automatic cmd_t late_cmds(stat_e k);
        cmd_t c;
        c = '0;
        case (k)
            ST_IOWR: c.iowr = 1'b1;
            ST_MWR:  c.mwr  = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsd_tracker.sv
module bsd_tracker
    import bsd_pkg::*;
#(
    parameter int WR_LAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] status,
    output phase_e            phase,
    output stat_e             kind,
    output logic              late_ok
);
    localparam int LAG_W = (WR_LAG < 1) ? 1 : $clog2(WR_LAG + 1);
    localparam logic [LAG_W-1:0] LAG_MAX = LAG_W'(WR_LAG);

    logic             armed_q;
    logic [LAG_W-1:0] lag_q;
    logic             passive;

    assign passive = (status == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= ST_IDLE;
            armed_q <= 1'b0;
            lag_q   <= '0;
        end else begin
            armed_q <= passive;
            case (phase)
                PH_IDLE: begin
                    if (armed_q && !passive) begin
                        phase <= PH_ADDR;
                        kind  <= stat_e'(status);
                    end
                end
                PH_ADDR: begin
                    lag_q <= '0;
                    phase <= passive ? PH_IDLE : PH_DATA;
                end
                PH_DATA: begin
                    if (passive) begin
                        phase <= PH_IDLE;
                    end else if (lag_q != LAG_MAX) begin
                        lag_q <= lag_q + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign late_ok = (phase == PH_DATA) && (lag_q == LAG_MAX);

    // R8: the captured kind holds for the whole data phase
    p_kind_held_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) != PH_IDLE) |-> $stable(kind));

    // R2: address phase only follows idle
    p_addr_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_ADDR) |-> $past(phase) == PH_IDLE);

endmodule

// File: rtl/bsd_cmd_decode.sv
module bsd_cmd_decode
    import bsd_pkg::*;
(
    input  phase_e phase,
    input  stat_e  kind,
    input  logic   late_ok,
    output cmd_t   cmd,
    output logic   ale,
    output logic   den,
    output logic   dtr
);
    logic in_data;
    logic active;

    assign in_data = (phase == PH_DATA);
    assign active  = (phase != PH_IDLE);

    always_comb begin
        cmd = '0;
        if (in_data) begin
            cmd = early_cmds(kind);
            if (late_ok) begin
                cmd = cmd | late_cmds(kind);
            end
        end
    end

    assign ale = (phase == PH_ADDR);
    assign den = in_data && (kind != ST_HALT);
    assign dtr = !(active && is_receive(kind));

endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bsd_pkg::*;
#(
    parameter int WR_LAG = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_status,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       mem_wr_adv_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       io_wr_adv_n,
    output logic       int_ack_n,
    output logic       addr_latch,
    output logic       data_en,
    output logic       data_dir
);
    phase_e phase;
    stat_e  kind;
    logic   late_ok;
    cmd_t   cmd;

    bsd_tracker #(.WR_LAG(WR_LAG)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .status  (bus_status),
        .phase   (phase),
        .kind    (kind),
        .late_ok (late_ok)
    );

    bsd_cmd_decode u_decode (
        .phase   (phase),
        .kind    (kind),
        .late_ok (late_ok),
        .cmd     (cmd),
        .ale     (addr_latch),
        .den     (data_en),
        .dtr     (data_dir)
    );

    assign mem_rd_n     = ~cmd.mrd;
    assign mem_wr_n     = ~cmd.mwr;
    assign mem_wr_adv_n = ~cmd.amw;
    assign io_rd_n      = ~cmd.iord;
    assign io_wr_n      = ~cmd.iowr;
    assign io_wr_adv_n  = ~cmd.aiow;
    assign int_ack_n    = ~cmd.inta;

    // R2: latch strobe lasts one clock
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        addr_latch |=> !addr_latch);

    // R7: a sampled passive code leaves no command behind
    p_passive_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_status == 3'b111) |=> (cmd == '0) && !data_en);

    // R6: halt drives nothing
    p_halt_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (kind == ST_HALT && phase != PH_IDLE) |-> (cmd == '0) && !data_en);

    // R5: normal write never leads its advanced write
    p_write_order_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_wr_n |-> !mem_wr_adv_n) and (!io_wr_n |-> !io_wr_adv_n));

    // R11: at most two strobes at once
    p_cmd_count_r11: assert property (@(posedge clk) disable iff (rst)
        $countones(cmd) <= 2);

endmodule

// File: tb/test_bus_cmd_decoder.sv
module test_bus_cmd_decoder;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_status = 3'b111;
    logic mem_rd_n, mem_wr_n, mem_wr_adv_n, io_rd_n, io_wr_n, io_wr_adv_n, int_ack_n;
    logic addr_latch, data_en, data_dir;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cmd_decoder i_bus_cmd_decoder (
        .clk(clk), .rst(rst), .bus_status(bus_status),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_adv_n(mem_wr_adv_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_adv_n(io_wr_adv_n),
        .int_ack_n(int_ack_n), .addr_latch(addr_latch),
        .data_en(data_en), .data_dir(data_dir)
    );

    // bit order: 6 inta, 5 iord, 4 iowr, 3 aiow, 2 mrd, 1 mwr, 0 amw (active high)
    function automatic logic [6:0] obs_cmds();
        return ~{int_ack_n, io_rd_n, io_wr_n, io_wr_adv_n, mem_rd_n, mem_wr_n, mem_wr_adv_n};
    endfunction

    function automatic logic [6:0] exp_early(input logic [2:0] c);
        case (c)
            3'b000: return 7'b1000000;
            3'b001: return 7'b0100000;
            3'b010: return 7'b0001000;
            3'b100, 3'b101: return 7'b0000100;
            3'b110: return 7'b0000001;
            default: return 7'b0;
        endcase
    endfunction

    function automatic logic [6:0] exp_late(input logic [2:0] c);
        case (c)
            3'b010: return 7'b0011000;
            3'b110: return 7'b0000011;
            default: return exp_early(c);
        endcase
    endfunction

    function automatic logic exp_dir(input logic [2:0] c);
        return !(c == 3'b000 || c == 3'b001 || c == 3'b100 || c == 3'b101);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk({req, " cmds"}, {25'd0, obs_cmds()}, 32'd0);
        chk({req, " ale"}, {31'd0, addr_latch}, 32'd0);
        chk({req, " den"}, {31'd0, data_en}, 32'd0);
        chk({req, " dir"}, {31'd0, data_dir}, 32'd1);
    endtask

    // full cycle: start edge, latch clock, data clocks, passive end
    task automatic run_cycle(input logic [2:0] code, input int data_clks);
        logic [2:0] c = code;
        bus_status = c;
        @(negedge clk);
        chk("R2 ale start", {31'd0, addr_latch}, 32'd1);
        chk("R3 R4 no cmd in latch clock", {25'd0, obs_cmds()}, 32'd0);
        chk("R9 dir latch clock", {31'd0, data_dir}, {31'd0, exp_dir(c)});
        @(negedge clk);
        chk("R2 ale one clock", {31'd0, addr_latch}, 32'd0);
        chk((c == 3'b010 || c == 3'b110) ? "R4 advanced write" : "R3 R6 early cmd",
            {25'd0, obs_cmds()}, {25'd0, exp_early(c)});
        chk("R10 R6 den", {31'd0, data_en}, {31'd0, c != 3'b011});
        for (int i = 1; i < data_clks; i++) begin
            @(negedge clk);
            chk("R5 R11 late cmd", {25'd0, obs_cmds()}, {25'd0, exp_late(c)});
            chk("R9 dir data", {31'd0, data_dir}, {31'd0, exp_dir(c)});
            chk("R10 den hold", {31'd0, data_en}, {31'd0, c != 3'b011});
        end
        bus_status = 3'b111;
        @(negedge clk);
        chk_idle("R7 end");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        bus_status = 3'b111;
        repeat (2) @(negedge clk);
        chk_idle("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 after release");
    endtask

    task automatic t_decode_all();
        run_cycle(3'b000, 2);
        run_cycle(3'b001, 3);
        run_cycle(3'b100, 2);
        run_cycle(3'b101, 4);
        run_cycle(3'b010, 3);
        run_cycle(3'b110, 4);
        run_cycle(3'b011, 3);
    endtask

    task automatic t_held_through_reset();
        rst = 1'b1;
        bus_status = 3'b101;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 no start without passive ale", {31'd0, addr_latch}, 32'd0);
            chk("R2 no start without passive cmds", {25'd0, obs_cmds()}, 32'd0);
        end
        bus_status = 3'b111;
        @(negedge clk);
        run_cycle(3'b101, 2);
    endtask

    task automatic t_abort_in_latch();
        bus_status = 3'b110;
        @(negedge clk);
        chk("R2 abort ale", {31'd0, addr_latch}, 32'd1);
        bus_status = 3'b111;
        @(negedge clk);
        chk_idle("R7 abort");
        @(negedge clk);
        chk_idle("R7 abort stays idle");
    endtask

    task automatic t_code_change();
        bus_status = 3'b110;
        @(negedge clk);
        @(negedge clk);
        bus_status = 3'b001;
        @(negedge clk);
        chk("R8 kept memory write", {25'd0, obs_cmds()}, {25'd0, exp_late(3'b110)});
        chk("R8 dir kept", {31'd0, data_dir}, 32'd1);
        bus_status = 3'b000;
        @(negedge clk);
        chk("R8 still memory write", {25'd0, obs_cmds()}, {25'd0, exp_late(3'b110)});
        chk("R8 no second ale", {31'd0, addr_latch}, 32'd0);
        bus_status = 3'b111;
        @(negedge clk);
        chk_idle("R7 after change");
    endtask

    task automatic t_back_to_back();
        run_cycle(3'b010, 2);
        run_cycle(3'b001, 2);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_decode_all();
        t_held_through_reset();
        t_abort_in_latch();
        t_code_change();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule